// File: doc/BRIEF.md
# Receive Repeated-Character Detector

This block sits beside the write port of a receive FIFO and watches every byte that a serial receiver pushes into it. Software programs a character of interest and a required run length. When that character arrives back to back the required number of times, the block sets a sticky status flag and, while detection is enabled, drives an interrupt line. A byte-synchronous link can use it to learn that a frame has ended, for example when a terminator byte repeats, without polling the FIFO contents.

The host reaches the block through a small register port with four byte-wide locations. These hold the character, the run length, a control byte with the enable and a receive-flush bit, and a status byte whose flag is cleared by writing a one. The block never alters the byte stream or the FIFO. It only observes the write strobe and the data.

Top module: `rx_run_detect`

## Requirements
- R1: Register map at `cfg_addr`: 0 = pattern character (8 bits), 1 = required run length (8 bits), 2 = control (bit 6 enable, bit 4 receive flush, all other bits read 0), 3 = status (bit 0 flag, other bits read 0). After reset every register reads 0 and `irq` is 0.
- R2: While enabled and not flushing, a strobed byte equal to the pattern character adds one to the run counter. The counter saturates at 255 and does not wrap.
- R3: While enabled, a strobed byte that differs from the pattern character sets the run counter to zero. Only consecutive matches count.
- R4: The flag is set by the matching byte that makes the run counter equal the required length. The flag reads 1 right after the clock edge that takes that byte.
- R5: A required length of 0 never sets the flag.
- R6: The flag stays set until the host writes a 1 to status bit 0. Writing 0 there has no effect. If a setting byte and a clearing write arrive in the same cycle, the flag ends up set.
- R7: While the enable bit is 0, the run counter is held at zero and strobed bytes are ignored. The flag keeps its value.
- R8: While the receive flush bit is 1, the run counter is held at zero and strobed bytes are ignored.
- R9: `irq` is high exactly when the flag is set and the enable bit is 1.
- R10: Once the run counter already equals the required length, or has moved past it, further matching bytes do not set the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | Strobe: one byte is being written into the receive FIFO this cycle |
| byte_data | input | 8 | The byte being written |
| cfg_we | input | 1 | Host register write enable |
| cfg_addr | input | 2 | Host register address, used for both reads and writes |
| cfg_wdata | input | 8 | Host write data |
| cfg_rdata | output | 8 | Host read data for `cfg_addr` (combinational) |
| irq | output | 1 | Interrupt: flag AND enable |

## Verification
The bench targets several corner cases, each of which shows a specific bug.

- **Run length of 255.** A counter that wraps, or that compares before it increments, fires at the wrong byte or never fires.
- **Run length of 0.** A design that skips the zero guard raises the flag on the first byte, or on any byte.
- **Run broken one byte short.** A missing reset on a non-matching byte lets the flag fire early.
- **Run interrupted by disable or flush.** The same missing reset shows up here as an early flag.
- **Matches after a cleared flag.** A design without the "first equals" condition sets the flag again.
- **Set and clear in the same cycle.** The wrong priority loses the event.

On top of these directed cases, the bench runs a seeded random stream drawn from a small alphabet, which produces long runs, and clears the flag at random points.

// File: rtl/rxrd_pkg.sv
package rxrd_pkg;
  localparam int unsigned RXRD_W      = 8;
  localparam int unsigned RXRD_AW     = 2;
  localparam int unsigned CTL_EN_BIT  = 6;
  localparam int unsigned CTL_FL_BIT  = 4;
  localparam int unsigned STS_FLG_BIT = 0;

  localparam logic [RXRD_AW-1:0] A_PAT = 2'd0;
  localparam logic [RXRD_AW-1:0] A_CNT = 2'd1;
  localparam logic [RXRD_AW-1:0] A_CTL = 2'd2;
  localparam logic [RXRD_AW-1:0] A_STS = 2'd3;

  // Run counter step: zero on a miss, saturating increment on a hit.
  function automatic logic [RXRD_W-1:0] rxrd_next_run(input logic [RXRD_W-1:0] run,
                                                      input logic is_match);
    if (!is_match)      return '0;
    else if (&run)      return run;
    else                return run + 1'b1;
  endfunction

  // True only when the run first reaches a non-zero target.
  function automatic logic rxrd_fires(input logic [RXRD_W-1:0] run,
                                      input logic [RXRD_W-1:0] nxt,
                                      input logic [RXRD_W-1:0] target);
    return (target != '0) && (nxt == target) && (run != target);
  endfunction
endpackage

// File: rtl/rxrd_regs.sv
module rxrd_regs
  import rxrd_pkg::*;
#(
  parameter int unsigned W  = RXRD_W,
  parameter int unsigned AW = RXRD_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [W-1:0]  cfg_wdata,
  input  logic          flag_q,
  output logic [W-1:0]  pat_q,
  output logic [W-1:0]  cnt_q,
  output logic          en_q,
  output logic          flush_q,
  output logic          clr_evt,
  output logic [W-1:0]  cfg_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q   <= '0;
      cnt_q   <= '0;
      en_q    <= 1'b0;
      flush_q <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        A_PAT: pat_q <= cfg_wdata;
        A_CNT: cnt_q <= cfg_wdata;
        A_CTL: begin
          en_q    <= cfg_wdata[CTL_EN_BIT];
          flush_q <= cfg_wdata[CTL_FL_BIT];
        end
        default: ;
      endcase
    end
  end

  assign clr_evt = cfg_we && (cfg_addr == A_STS) && cfg_wdata[STS_FLG_BIT];

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      A_PAT: cfg_rdata = pat_q;
      A_CNT: cfg_rdata = cnt_q;
      A_CTL: begin
        cfg_rdata[CTL_EN_BIT] = en_q;
        cfg_rdata[CTL_FL_BIT] = flush_q;
      end
      default: cfg_rdata[STS_FLG_BIT] = flag_q;
    endcase
  end
endmodule

// File: rtl/rxrd_run_ctr.sv
module rxrd_run_ctr
  import rxrd_pkg::*;
#(
  parameter int unsigned W = RXRD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         byte_vld,
  input  logic [W-1:0] byte_data,
  input  logic [W-1:0] pat_q,
  input  logic [W-1:0] cnt_q,
  input  logic         en_q,
  input  logic         flush_q,
  output logic [W-1:0] run_q,
  output logic         match_evt,
  output logic         hit_evt
);
  logic         active;
  logic [W-1:0] run_nxt;

  assign active    = byte_vld && en_q && !flush_q;
  assign match_evt = (byte_data == pat_q);
  assign run_nxt   = rxrd_next_run(run_q, match_evt);
  assign hit_evt   = active && match_evt && rxrd_fires(run_q, run_nxt, cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run_q <= '0;
    else if (!en_q || flush_q) run_q <= '0;
    else if (byte_vld)         run_q <= run_nxt;
  end
endmodule

// File: rtl/rxrd_flag.sv
module rxrd_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_evt,
  input  logic clr_evt,
  input  logic en_q,
  output logic flag_q,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (hit_evt) flag_q <= 1'b1;
    else if (clr_evt) flag_q <= 1'b0;
  end

  assign irq = flag_q && en_q;
endmodule

// File: rtl/rx_run_detect.sv
module rx_run_detect
  import rxrd_pkg::*;
#(
  parameter int unsigned W  = RXRD_W,
  parameter int unsigned AW = RXRD_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_vld,
  input  logic [W-1:0]  byte_data,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [W-1:0]  cfg_wdata,
  output logic [W-1:0]  cfg_rdata,
  output logic          irq
);
  logic [W-1:0] pat_q, cnt_q, run_q;
  logic         en_q, flush_q, clr_evt, match_evt, hit_evt, flag_q;

  rxrd_regs #(.W(W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .flag_q(flag_q), .pat_q(pat_q), .cnt_q(cnt_q),
    .en_q(en_q), .flush_q(flush_q), .clr_evt(clr_evt), .cfg_rdata(cfg_rdata)
  );

  rxrd_run_ctr #(.W(W)) u_run (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
    .pat_q(pat_q), .cnt_q(cnt_q), .en_q(en_q), .flush_q(flush_q),
    .run_q(run_q), .match_evt(match_evt), .hit_evt(hit_evt)
  );

  rxrd_flag u_flag (
    .clk(clk), .rst_n(rst_n), .hit_evt(hit_evt), .clr_evt(clr_evt),
    .en_q(en_q), .flag_q(flag_q), .irq(irq)
  );
endmodule

// File: rtl/rxrd_chk.sv
module rxrd_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         byte_vld,
  input logic         match_evt,
  input logic         en_q,
  input logic         flush_q,
  input logic [W-1:0] run_q,
  input logic [W-1:0] cnt_q,
  input logic         hit_evt,
  input logic         clr_evt,
  input logic         flag_q
);
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && en_q && !flush_q && match_evt && (&run_q)) |=> (&run_q)); // R2
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !match_evt) |=> (run_q == '0)); // R3
  AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> flag_q); // R4
  AST_ROSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(hit_evt)); // R4
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == '0) && !flag_q) |=> !flag_q); // R5
  AST_FLAG_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_evt) |=> flag_q); // R6
  AST_EN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (run_q == '0)); // R7
  AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |=> (run_q == '0)); // R8
  AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q == cnt_q) |-> !hit_evt); // R10
endmodule

bind rx_run_detect rxrd_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .match_evt(match_evt),
  .en_q(en_q), .flush_q(flush_q), .run_q(run_q), .cnt_q(cnt_q),
  .hit_evt(hit_evt), .clr_evt(clr_evt), .flag_q(flag_q)
);

// File: tb/tb_rx_run_detect.sv
`timescale 1ns/1ps
module tb_rx_run_detect;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_data = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model state
  logic [7:0] m_pat = 0, m_cnt = 0, m_run = 0;
  logic       m_en = 0, m_fl = 0, m_flag = 0;

  always #2.5 clk = ~clk;

  rx_run_detect dut (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // Run length after one more byte, written as a count of consecutive hits.
  function automatic logic [7:0] exp_run(input logic [7:0] run, input logic hit);
    int r;
    r = hit ? int'(run) + 1 : 0;
    if (r > 255) r = 255;
    return 8'(r);
  endfunction

  function automatic void model_byte(input logic [7:0] b);
    logic [7:0] nr;
    if (m_en && !m_fl) begin
      nr = exp_run(m_run, b == m_pat);
      if (b == m_pat && m_cnt != 0 && nr == m_cnt && m_run < m_cnt) m_flag = 1;
      m_run = nr;
    end
  endfunction

  function automatic void model_wr(input logic [1:0] a, input logic [7:0] d);
    case (a)
      2'd0: m_pat = d;
      2'd1: m_cnt = d;
      2'd2: begin m_en = d[6]; m_fl = d[4]; if (!m_en || m_fl) m_run = 0; end
      default: if (d[0]) m_flag = 0;
    endcase
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1; cfg_we = 0;
    model_wr(a, d);
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); byte_vld = 1; byte_data = b;
    @(posedge clk); #1; byte_vld = 0;
    model_byte(b);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic chk_flag(input string tag);
    logic [7:0] s;
    rd(2'd3, s);
    chk({tag, " status"}, s, {7'd0, m_flag});
    chk({tag, " irq"}, {7'd0, irq}, {7'd0, m_flag & m_en});
  endtask

  initial begin
    #(5 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int seed_init;
    seed_init = $urandom(32'd2718);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset values
    for (int a = 0; a < 4; a++) begin rd(2'(a), d); chk("R1 reset reg", d, 8'h00); end
    chk("R1 reset irq", {7'd0, irq}, 8'h00);

    wr(2'd0, 8'h7E); wr(2'd1, 8'd3); wr(2'd2, 8'hFF);
    rd(2'd0, d); chk("R1 pattern readback", d, 8'h7E);
    rd(2'd1, d); chk("R1 length readback", d, 8'h03);
    rd(2'd2, d); chk("R1 control readback", d, 8'h50);
    wr(2'd2, 8'h40);

    // R2/R4 basic run of three
    push(8'h7E); push(8'h7E); chk_flag("R4 before target");
    push(8'h7E); chk_flag("R4 at target");
    chk("R9 irq high", {7'd0, irq}, 8'h01);

    // R6 write 0 has no effect; write 1 clears
    wr(2'd3, 8'h00); chk_flag("R6 zero write");
    wr(2'd3, 8'h01); chk_flag("R6 cleared");
    // R10 more matches past target do not refire
    push(8'h7E); push(8'h7E); chk_flag("R10 no refire");

    // R3 broken run
    push(8'h41); push(8'h7E); push(8'h7E); push(8'h41);
    push(8'h7E); push(8'h7E); chk_flag("R3 broken run");
    push(8'h7E); chk_flag("R3 run completes");
    wr(2'd3, 8'h01);

    // R5 length zero
    wr(2'd1, 8'd0);
    for (int i = 0; i < 300; i++) push(8'h7E);
    chk_flag("R5 zero length");

    // R7 disable resets run, ignores bytes, keeps flag
    wr(2'd1, 8'd3);
    push(8'h41); push(8'h7E); push(8'h7E);
    wr(2'd2, 8'h00); wr(2'd2, 8'h40);
    push(8'h7E); chk_flag("R7 run reset by disable");
    push(8'h7E); push(8'h7E); chk_flag("R7 run after re-enable");
    wr(2'd2, 8'h00);
    chk_flag("R9 irq gated by enable");
    rd(2'd3, d); chk("R7 flag kept while disabled", d, 8'h01);
    wr(2'd3, 8'h01);
    push(8'h7E); push(8'h7E); push(8'h7E);
    wr(2'd2, 8'h40);
    chk_flag("R7 bytes ignored while disabled");
    push(8'h7E); push(8'h7E); chk_flag("R7 fresh run partial");
    push(8'h7E); chk_flag("R7 fresh run full");
    wr(2'd3, 8'h01);

    // R8 flush
    push(8'h41); push(8'h7E); push(8'h7E);
    wr(2'd2, 8'h50);
    push(8'h7E); push(8'h7E); chk_flag("R8 ignored during flush");
    wr(2'd2, 8'h40);
    push(8'h7E); chk_flag("R8 run reset by flush");
    push(8'h7E); push(8'h7E); chk_flag("R8 run after flush");
    wr(2'd3, 8'h01);

    // R2 saturation boundary, length 255
    wr(2'd1, 8'd255); push(8'h41);
    for (int i = 0; i < 254; i++) push(8'h7E);
    chk_flag("R2 254 matches");
    push(8'h7E); chk_flag("R2 255th match");
    wr(2'd3, 8'h01);
    for (int i = 0; i < 5; i++) push(8'h7E);
    chk_flag("R2 saturated no refire");

    // R6 set wins over clear
    wr(2'd1, 8'd2); push(8'h41); push(8'h7E);
    @(negedge clk);
    byte_vld = 1; byte_data = 8'h7E; cfg_we = 1; cfg_addr = 2'd3; cfg_wdata = 8'h01;
    @(posedge clk); #1; byte_vld = 0; cfg_we = 0;
    m_run = 2; m_flag = 1;
    chk_flag("R6 set beats clear");
    wr(2'd3, 8'h01);

    // random stream
    for (int i = 0; i < 1500; i++) begin
      int k;
      k = $urandom_range(0, 19);
      if (k == 0)      wr(2'd1, 8'($urandom_range(0, 6)));
      else if (k == 1) wr(2'd3, 8'($urandom_range(0, 1)));
      else if (k == 2) wr(2'd0, 8'($urandom_range(8'h30, 8'h32)));
      else if (k == 3) wr(2'd2, ($urandom_range(0, 7) == 0) ? 8'h00 : 8'h40);
      else             push(8'($urandom_range(8'h30, 8'h32)));
      if (i % 10 == 0) chk_flag("R4 random stream");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule